// File: doc/BRIEF.md
# Multi-Core Local Interrupt Router

The router collects the interrupt sources that belong to a small cluster of processor cores and steers each one onto either the normal interrupt line (IRQ) or the fast interrupt line (FIQ) of a core. Every core has four timer interrupt levels and four mailbox-pending levels of its own. One shared upstream IRQ and one shared upstream FIQ are also delivered, each to a single core that software picks.

Software sets the steering through a 32-bit register port with a simple valid/write/address/data handshake. Each core has a timer steering byte and a mailbox steering byte. A route register holds the core choice for the two shared lines. Two read-only status words per core show which sources are asserting that core's IRQ and FIQ. All sources are level-sensitive. The status words and core outputs are computed from registered inputs and registered configuration, so any change shows up on the cycle after the clock edge that samples it.

Top module: `core_irq_router`

## Requirements
- R1: For local source n (0..3) of a steering byte, a set bit n+4 sends an active source to FIQ only, a clear bit n+4 with a set bit n sends it to IRQ, and with both clear the source is masked.
- R2: In each core's status words, bits 0..3 are timers 0..3, bits 4..7 are mailboxes 0..3 (steered by the mailbox byte), bit 8 is the shared line, and bits 9..31 read as zero.
- R3: The route register at offset 0x0C keeps bits [1:0] as the core index for the shared IRQ and bits [3:2] as the core index for the shared FIQ. A read returns those four bits, with zeros above them. Only the chosen core sees the shared line, in status bit 8.
- R4: The timer steering byte of core c is at 0x40+4c and the mailbox steering byte is at 0x50+4c. A write keeps only data bits [7:0], and a read returns them zero-extended.
- R5: The IRQ status word of core c is read at 0x60+4c and the FIQ status word at 0x70+4c. A write to these offsets changes nothing and raises no error.
- R6: core_irq[c] is high exactly when the IRQ status word of core c is nonzero, and core_fiq[c] is high exactly when the FIQ status word of core c is nonzero.
- R7: Status words and outputs follow the current source levels. A change on an input or a register write shows up on the cycle after the clock edge that samples it, and not before. A source that goes low clears its bit.
- R8: After reset, both routes select core 0, all steering bytes are zero, and all outputs are low.
- R9: An access to an unmapped or non-word-aligned offset reads 0, changes no state, and raises reg_err for exactly one cycle, on the cycle after the access.
- R10: Read data is presented on reg_rdata on the cycle after a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| reg_err | output | 1 | One-cycle pulse after an unmapped access |
| timer_lvl | input | 16 | Timer levels, core c at bits [4c+3:4c] |
| mbox_pend | input | 16 | Mailbox pending levels, core c at bits [4c+3:4c] |
| shared_irq | input | 1 | Shared upstream IRQ level |
| shared_fiq | input | 1 | Shared upstream FIQ level |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
Directed cases cover each steering bit pair on its own: FIQ only, IRQ only, both, and none. These show the FIQ-over-IRQ priority apart from plain masking. Shared-route cases put the IRQ and the FIQ on different cores, which shows whether the two route fields are swapped or decoded into the wrong bit position. Random mixes of source levels and steering bytes, with full status readback, expose cross-core leakage and a wrong slot for a mailbox or timer bit. Level drops and a sample taken just before the clock edge tell level-sensitive behaviour apart from latched behaviour and check the one-cycle latency.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int LOCAL_SRC   = 4;
   localparam int TMR_BASE    = 0;
   localparam int MBX_BASE    = 4;
   localparam int SHARED_BIT  = 8;
   localparam int STEER_W     = 8;
   localparam int ROUTE_W     = 2;

   localparam logic [7:0] OFF_ROUTE = 8'h0C;
   localparam logic [3:0] GRP_TMR   = 4'h4;
   localparam logic [3:0] GRP_MBX   = 4'h5;
   localparam logic [3:0] GRP_IRQW  = 4'h6;
   localparam logic [3:0] GRP_FIQW  = 4'h7;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_ROUTE, SEL_TMR, SEL_MBX, SEL_IRQW, SEL_FIQW
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e          sel;
      logic [ROUTE_W-1:0] idx;
   } reg_dec_t;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_dec_t          dec
);
   localparam int HI_SHIFT = 8;

   logic hi_zero;
   logic idx_ok;

   always_comb begin
      hi_zero = ((addr >> HI_SHIFT) == '0);
      idx_ok  = (int'(addr[3:2]) < NUM_CORES);
      dec.idx = addr[3:2];
      dec.sel = SEL_NONE;
      if (hi_zero && (addr[1:0] == 2'b00)) begin
         if (addr[7:0] == OFF_ROUTE) begin
            dec.sel = SEL_ROUTE;
         end else if (idx_ok) begin
            case (addr[7:4])
               GRP_TMR:  dec.sel = SEL_TMR;
               GRP_MBX:  dec.sel = SEL_MBX;
               GRP_IRQW: dec.sel = SEL_IRQW;
               GRP_FIQW: dec.sel = SEL_FIQW;
               default:  dec.sel = SEL_NONE;
            endcase
         end
      end
   end
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
   import irq_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  valid,
   input  logic                                  write,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic [DATA_W-1:0]                     wdata,
   input  logic [NUM_CORES-1:0][DATA_W-1:0]      irq_words,
   input  logic [NUM_CORES-1:0][DATA_W-1:0]      fiq_words,
   output logic [NUM_CORES-1:0][STEER_W-1:0]     tmr_ctrl,
   output logic [NUM_CORES-1:0][STEER_W-1:0]     mbx_ctrl,
   output logic [ROUTE_W-1:0]                    irq_route,
   output logic [ROUTE_W-1:0]                    fiq_route,
   output logic [DATA_W-1:0]                     rdata,
   output logic                                  err
);
   reg_dec_t          dec;
   logic [DATA_W-1:0] rd_mux;
   logic              wr_en;
   logic              rd_en;

   irq_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .dec  (dec)
   );

   assign wr_en = valid && write;
   assign rd_en = valid && !write;

   always_comb begin
      rd_mux = '0;
      case (dec.sel)
         SEL_ROUTE: rd_mux = DATA_W'({fiq_route, irq_route});
         SEL_TMR:   rd_mux = DATA_W'(tmr_ctrl[dec.idx]);
         SEL_MBX:   rd_mux = DATA_W'(mbx_ctrl[dec.idx]);
         SEL_IRQW:  rd_mux = irq_words[dec.idx];
         SEL_FIQW:  rd_mux = fiq_words[dec.idx];
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_ctrl  <= '0;
         mbx_ctrl  <= '0;
         irq_route <= '0;
         fiq_route <= '0;
         rdata     <= '0;
         err       <= 1'b0;
      end else begin
         err <= valid && (dec.sel == SEL_NONE);
         if (rd_en) rdata <= rd_mux;
         if (wr_en) begin
            case (dec.sel)
               SEL_ROUTE: begin
                  irq_route <= wdata[ROUTE_W-1:0];
                  fiq_route <= wdata[2*ROUTE_W-1:ROUTE_W];
               end
               SEL_TMR: tmr_ctrl[dec.idx] <= wdata[STEER_W-1:0];
               SEL_MBX: mbx_ctrl[dec.idx] <= wdata[STEER_W-1:0];
               default: ;
            endcase
         end
      end
   end

   AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(valid)); // R9

   AST_CONFIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ($stable(tmr_ctrl) && $stable(mbx_ctrl)
                         && $stable(irq_route) && $stable(fiq_route))); // R4

   AST_ROUTE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec.sel == SEL_ROUTE) |=> (irq_route == $past(wdata[1:0])
                                         && fiq_route == $past(wdata[3:2]))); // R3
endmodule

// File: rtl/irq_core_steer.sv
module irq_core_steer
   import irq_router_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [LOCAL_SRC-1:0] tmr_lvl,
   input  logic [LOCAL_SRC-1:0] mbx_lvl,
   input  logic [STEER_W-1:0]   tmr_ctrl,
   input  logic [STEER_W-1:0]   mbx_ctrl,
   input  logic                 shared_irq_hit,
   input  logic                 shared_fiq_hit,
   output logic [DATA_W-1:0]    irq_word,
   output logic [DATA_W-1:0]    fiq_word
);
   logic [LOCAL_SRC-1:0] t_irq, t_fiq, m_irq, m_fiq;

   for (genvar n = 0; n < LOCAL_SRC; n++) begin : g_src
      assign t_fiq[n] = tmr_lvl[n] &  tmr_ctrl[n+LOCAL_SRC];
      assign t_irq[n] = tmr_lvl[n] & ~tmr_ctrl[n+LOCAL_SRC] & tmr_ctrl[n];
      assign m_fiq[n] = mbx_lvl[n] &  mbx_ctrl[n+LOCAL_SRC];
      assign m_irq[n] = mbx_lvl[n] & ~mbx_ctrl[n+LOCAL_SRC] & mbx_ctrl[n];
   end

   always_comb begin
      irq_word = '0;
      fiq_word = '0;
      irq_word[TMR_BASE +: LOCAL_SRC] = t_irq;
      fiq_word[TMR_BASE +: LOCAL_SRC] = t_fiq;
      irq_word[MBX_BASE +: LOCAL_SRC] = m_irq;
      fiq_word[MBX_BASE +: LOCAL_SRC] = m_fiq;
      irq_word[SHARED_BIT] = shared_irq_hit;
      fiq_word[SHARED_BIT] = shared_fiq_hit;
   end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
   import irq_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   localparam int SRC_W    = NUM_CORES * LOCAL_SRC
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_valid,
   input  logic                 reg_write,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic                 reg_err,
   input  logic [SRC_W-1:0]     timer_lvl,
   input  logic [SRC_W-1:0]     mbox_pend,
   input  logic                 shared_irq,
   input  logic                 shared_fiq,
   output logic [NUM_CORES-1:0] core_irq,
   output logic [NUM_CORES-1:0] core_fiq
);
   if (NUM_CORES < 1 || NUM_CORES > (1 << ROUTE_W)) begin : g_bad_cores
      $error("NUM_CORES must be 1..4");
   end
   if (DATA_W < SHARED_BIT + 1) begin : g_bad_width
      $error("DATA_W too narrow for the status word layout");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover offsets up to 0xFF");
   end

   logic [SRC_W-1:0]                     tmr_q, mbx_q;
   logic                                 sh_irq_q, sh_fiq_q;
   logic [NUM_CORES-1:0][STEER_W-1:0]    tmr_ctrl, mbx_ctrl;
   logic [ROUTE_W-1:0]                   irq_route, fiq_route;
   logic [NUM_CORES-1:0][DATA_W-1:0]     irq_words, fiq_words;
   logic [NUM_CORES-1:0]                 shared_irq_col, shared_fiq_col;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q    <= '0;
         mbx_q    <= '0;
         sh_irq_q <= 1'b0;
         sh_fiq_q <= 1'b0;
      end else begin
         tmr_q    <= timer_lvl;
         mbx_q    <= mbox_pend;
         sh_irq_q <= shared_irq;
         sh_fiq_q <= shared_fiq;
      end
   end

   irq_router_regs #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (reg_valid),
      .write     (reg_write),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .irq_words (irq_words),
      .fiq_words (fiq_words),
      .tmr_ctrl  (tmr_ctrl),
      .mbx_ctrl  (mbx_ctrl),
      .irq_route (irq_route),
      .fiq_route (fiq_route),
      .rdata     (reg_rdata),
      .err       (reg_err)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic irq_hit, fiq_hit;
      assign irq_hit = sh_irq_q && (irq_route == ROUTE_W'(c));
      assign fiq_hit = sh_fiq_q && (fiq_route == ROUTE_W'(c));

      irq_core_steer #(.DATA_W(DATA_W)) u_steer (
         .tmr_lvl        (tmr_q[c*LOCAL_SRC +: LOCAL_SRC]),
         .mbx_lvl        (mbx_q[c*LOCAL_SRC +: LOCAL_SRC]),
         .tmr_ctrl       (tmr_ctrl[c]),
         .mbx_ctrl       (mbx_ctrl[c]),
         .shared_irq_hit (irq_hit),
         .shared_fiq_hit (fiq_hit),
         .irq_word       (irq_words[c]),
         .fiq_word       (fiq_words[c])
      );

      assign core_irq[c]       = |irq_words[c];
      assign core_fiq[c]       = |fiq_words[c];
      assign shared_irq_col[c] = irq_words[c][SHARED_BIT];
      assign shared_fiq_col[c] = fiq_words[c][SHARED_BIT];

      AST_FIQ_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_words[c][SHARED_BIT-1:0] & fiq_words[c][SHARED_BIT-1:0]) == '0); // R1

      AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_words[c] >> (SHARED_BIT + 1)) == '0
         && (fiq_words[c] >> (SHARED_BIT + 1)) == '0); // R2
   end

   AST_SHARED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(shared_irq_col) <= 1 && $countones(shared_fiq_col) <= 1); // R3

   AST_SHARED_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (|shared_irq_col) == sh_irq_q); // R3

   AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_q == '0 && mbx_q == '0 && !sh_irq_q && !sh_fiq_q)
      |-> (core_irq == '0 && core_fiq == '0)); // R6
endmodule

// File: tb/core_irq_router_test.sv
module core_irq_router_test;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0, reg_write = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_err;
   logic [15:0] timer_lvl = '0, mbox_pend = '0;
   logic        shared_irq = 1'b0, shared_fiq = 1'b0;
   logic [3:0]  core_irq, core_fiq;

   int checks = 0, fails = 0;
   logic [7:0] m_tmr [NC];
   logic [7:0] m_mbx [NC];
   logic [1:0] m_ir, m_fr;
   logic [31:0] rd;
   logic        er;

   always #(CLK_PERIOD/2) clk = ~clk;

   core_irq_router uut (
      .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_err(reg_err), .timer_lvl(timer_lvl), .mbox_pend(mbox_pend),
      .shared_irq(shared_irq), .shared_fiq(shared_fiq),
      .core_irq(core_irq), .core_fiq(core_fiq));

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int c, input bit fiq);
      logic [31:0] w = '0;
      for (int n = 0; n < 4; n++) begin
         if (timer_lvl[c*4+n]) begin
            if (m_tmr[c][n+4]) w[n] = fiq;
            else if (m_tmr[c][n]) w[n] = !fiq;
         end
         if (mbox_pend[c*4+n]) begin
            if (m_mbx[c][n+4]) w[n+4] = fiq;
            else if (m_mbx[c][n]) w[n+4] = !fiq;
         end
      end
      if (fiq) w[8] = shared_fiq && (int'(m_fr) == c);
      else     w[8] = shared_irq && (int'(m_ir) == c);
      return w;
   endfunction

   function automatic logic [3:0] exp_lines(input bit fiq);
      logic [3:0] v;
      for (int c = 0; c < NC; c++) v[c] = (exp_word(c, fiq) != 0);
      return v;
   endfunction

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_valid = 1'b0; reg_write = 1'b0;
      er = reg_err;
      if (a[1:0] == 2'b00) begin
         if (a == 8'h0C) begin m_ir = d[1:0]; m_fr = d[3:2]; end
         else if (a[7:4] == 4'h4) m_tmr[a[3:2]] = d[7:0];
         else if (a[7:4] == 4'h5) m_mbx[a[3:2]] = d[7:0];
      end
   endtask

   task automatic reg_rd(input logic [7:0] a);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      @(posedge clk); #1;
      reg_valid = 1'b0;
      rd = reg_rdata; er = reg_err;
   endtask

   task automatic set_in(input logic [15:0] t, input logic [15:0] m, input logic si, input logic sf);
      @(negedge clk);
      timer_lvl = t; mbox_pend = m; shared_irq = si; shared_fiq = sf;
      @(posedge clk); #1;
   endtask

   task automatic check_lines(input string req);
      check(core_irq == exp_lines(0), req, 32'(core_irq), 32'(exp_lines(0)));
      check(core_fiq == exp_lines(1), req, 32'(core_fiq), 32'(exp_lines(1)));
   endtask

   task automatic check_words(input int c, input string req);
      reg_rd(8'h60 + 8'(4*c));
      check(rd == exp_word(c, 0), req, rd, exp_word(c, 0));
      reg_rd(8'h70 + 8'(4*c));
      check(rd == exp_word(c, 1), req, rd, exp_word(c, 1));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int c = 0; c < NC; c++) begin m_tmr[c] = '0; m_mbx[c] = '0; end
      m_ir = '0; m_fr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;

      // R8: reset state
      check(core_irq == 0 && core_fiq == 0, "R8 outputs", {core_irq, core_fiq}, 0);
      reg_rd(8'h0C); check(rd == 0, "R8 route", rd, 0);
      reg_rd(8'h44); check(rd == 0, "R8 timer byte", rd, 0);
      reg_rd(8'h5C); check(rd == 0, "R8 mailbox byte", rd, 0);

      // R4 / R10: byte storage and readback the cycle after
      reg_wr(8'h44, 32'hFFFF_FF3C);
      reg_rd(8'h44); check(rd == 32'h3C, "R4 R10 timer byte trunc", rd, 32'h3C);
      reg_wr(8'h58, 32'h1234_56A5);
      reg_rd(8'h58); check(rd == 32'hA5, "R4 mailbox byte trunc", rd, 32'hA5);

      // R1: steering pairs on core 0 timer 0
      reg_wr(8'h40, 32'h11);
      set_in(16'h0001, 0, 0, 0);
      check_lines("R1 both bits -> fiq");
      check_words(0, "R1 both bits word");
      reg_wr(8'h40, 32'h01);
      check(core_irq == 4'b0001 && core_fiq == 0, "R1 irq only", {core_irq, core_fiq}, 32'h10);
      reg_wr(8'h40, 32'h10);
      check(core_fiq == 4'b0001 && core_irq == 0, "R1 fiq only", {core_irq, core_fiq}, 32'h01);
      reg_wr(8'h40, 32'h0E);
      check(core_irq == 0 && core_fiq == 0, "R1 masked", {core_irq, core_fiq}, 0);

      // R2: mailbox slot on core 3, bits 4..7
      reg_wr(8'h5C, 32'h08);
      set_in(0, 16'h8000, 0, 0);
      reg_rd(8'h6C); check(rd == 32'h80, "R2 mailbox3 bit7", rd, 32'h80);
      check_lines("R6 mailbox line");

      // R3: shared routes to distinct cores
      reg_wr(8'h0C, 32'hFFFF_FFF6);
      reg_rd(8'h0C); check(rd == 32'h6, "R3 route readback", rd, 32'h6);
      set_in(0, 0, 1, 1);
      reg_rd(8'h68); check(rd == 32'h100, "R3 shared irq core2", rd, 32'h100);
      reg_rd(8'h74); check(rd == 32'h100, "R3 shared fiq core1", rd, 32'h100);
      reg_rd(8'h60); check(rd == 32'h0, "R3 no irq core0", rd, 0);
      check_lines("R3 R6 shared lines");

      // R7: level drop, one-cycle latency
      @(negedge clk); shared_irq = 1'b0; #1;
      check(core_irq == 4'b0100, "R7 not before edge", 32'(core_irq), 32'h4);
      @(posedge clk); #1;
      check(core_irq == 4'b0000, "R7 cleared after edge", 32'(core_irq), 0);

      // R5: status words not writable
      reg_wr(8'h74, 32'hFFFF_FFFF);
      check(er == 0, "R5 no err on ro write", 32'(er), 0);
      reg_rd(8'h74); check(rd == 32'h100, "R5 ro unchanged", rd, 32'h100);

      // R9: unmapped and misaligned
      reg_rd(8'h20); check(rd == 0 && er == 1, "R9 unmapped read", {rd[30:0], er}, 1);
      @(posedge clk); #1; check(reg_err == 0, "R9 err one cycle", 32'(reg_err), 0);
      reg_wr(8'h41, 32'hFF);
      check(er == 1, "R9 misaligned err", 32'(er), 1);
      reg_rd(8'h40); check(rd == 32'h0E, "R9 misaligned no effect", rd, 32'h0E);
      reg_wr(8'h90, 32'hFF);
      check(er == 1, "R9 unmapped write err", 32'(er), 1);
      check_words(0, "R9 state intact");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 2));
         if (op == 0) begin
            set_in(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
            check_lines("R1 R2 R6 random lines");
         end else if (op == 1) begin
            int k;
            int c;
            k = int'($urandom_range(0, 2));
            c = int'($urandom_range(0, 3));
            if (k == 0) reg_wr(8'h0C, $urandom);
            else if (k == 1) reg_wr(8'h40 + 8'(4*c), $urandom);
            else reg_wr(8'h50 + 8'(4*c), $urandom);
            check_lines("R7 lines after write");
         end else begin
            check_words(int'($urandom_range(0, 3)), "R2 R3 random words");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule